// File: doc/BRIEF.md
# USB Suspend Resume Sequencer

This block brings a USB device out of suspend when the host begins resume signalling. While the device is suspended the block's own clock is normally stopped. A K state on the bus raises the active-high `awake` indication at once, without any clock edge. The active-low PHY suspend control follows that flag, so the PHY can restart the clock. When the clock runs again, the sequencer waits a set number of clock edges as proof of clock activity. It then measures the host's K signalling and waits for the closing SE0 followed by the return of J.

On that return it issues a one-cycle completion pulse. The device then runs at the speed it held when suspend was entered. That speed is latched on a suspend request and held unchanged until the next request. The bus line state is a 2-bit code: 00 is SE0, 01 is J and 10 is K. The code 11 is neither and is ignored. The line state passes through a two-flop synchronizer whenever the clock runs.

Top module: `usb_resume_seq`

## Requirements
- R1: After reset, `awake` is 1, `phy_suspend_n` is 1, `resume_done` is 0 and `speed_hs_out` is 0, and the block is in normal operation.
- R2: A `suspend_req` sampled in normal operation captures `speed_hs_in` into `speed_hs_out`, and drives `awake` and `phy_suspend_n` to 0 from that clock edge.
- R3: While suspended, `line_state` = 10 (K) sets `awake` to 1 with no clock edge. The codes 01 (J), 00 (SE0) and 11 leave it at 0.
- R4: `phy_suspend_n` is 1 only while `awake` is 1, so the PHY suspend is released exactly when the wake flag is seen.
- R5: Once the clock runs after wake-up, `CLK_WAIT` clock edges pass before K time is measured.
- R6: `resume_done` cannot occur before `K_MIN` clock cycles of synchronized K have been counted in the measuring phase. Non-K codes in that phase pause the count and do not end the resume.
- R7: After the K minimum is met, a synchronized SE0 followed by a synchronized J produces `resume_done` for exactly one cycle, and the block returns to normal operation.
- R8: `speed_hs_out` keeps the value captured at suspend entry through suspend and resume, whatever `speed_hs_in` does.
- R9: The code 11 after the K minimum is not taken as SE0. A following J without an SE0 does not complete the resume.
- R10: `suspend_req` outside normal operation is ignored. It neither clears `awake` nor recaptures the speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; may be stopped while suspended |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_state | input | 2 | Bus line code: 00 SE0, 01 J, 10 K |
| suspend_req | input | 1 | Suspend entry request, sampled in normal operation |
| speed_hs_in | input | 1 | Current speed, 1 for high speed, 0 for full speed |
| awake | output | 1 | Active-high wake indication, set asynchronously by K |
| phy_suspend_n | output | 1 | Active-low PHY suspend control |
| resume_done | output | 1 | One-cycle pulse on return to normal operation |
| speed_hs_out | output | 1 | Speed saved at suspend entry |

## Verification
Bus patterns during a stopped clock (J, SE0, 11, then K) separate a wake caused only by K from a wake caused by any code change. A K burst shorter than the minimum, followed by SE0 and J, shows that completion depends on measured K time and not just on the end-of-resume sequence. A burst that ends in 11 and then J, with no SE0, shows that only a true SE0 arms completion. Randomised rounds then vary the saved speed, the K length above the minimum, the SE0 length and the toggling of `speed_hs_in`. Each round checks that completion arrives as a single pulse and that the restored speed is the captured one. One round adds a stray suspend request in mid-resume.

// File: rtl/usb_rsm_pkg.sv
package usb_rsm_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_SUSP     = 3'd1,
        ST_WAKE     = 3'd2,
        ST_CLKWAIT  = 3'd3,
        ST_KMEAS    = 3'd4,
        ST_EOPWAIT  = 3'd5
    } rsm_state_e;

    localparam logic [1:0] LINE_SE0 = 2'b00;
    localparam logic [1:0] LINE_J   = 2'b01;
    localparam logic [1:0] LINE_K   = 2'b10;

endpackage

// File: rtl/rsm_line_sync.sv
module rsm_line_sync #(
    parameter int WIDTH = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q, stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= RESET_VAL;
            stable_q <= RESET_VAL;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/rsm_wake_flag.sv
module rsm_wake_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_async,
    input  logic clr_sync,
    output logic flag_o
);
    logic flag_q;

    // Set without a clock: the K state itself forces the flag high.
    always_ff @(posedge clk or posedge set_async or negedge rst_n) begin
        if (!rst_n)         flag_q <= 1'b1;
        else if (set_async) flag_q <= 1'b1;
        else if (clr_sync)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    assert_flag_follows_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_async |-> flag_q);
endmodule

// File: rtl/rsm_ctrl.sv
module rsm_ctrl
    import usb_rsm_pkg::*;
#(
    parameter int K_MIN    = 1200000,
    parameter int CLK_WAIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_s,
    input  logic       awake_i,
    input  logic       suspend_req,
    input  logic       speed_hs_in,
    output logic       suspended_o,
    output logic       awake_clr_o,
    output logic       resume_done,
    output logic       speed_hs_out
);
    localparam int KW = $clog2(K_MIN + 1);
    localparam int WW = $clog2(CLK_WAIT + 1);
    localparam logic [KW-1:0] K_LAST = KW'(K_MIN - 1);
    localparam logic [WW-1:0] W_LAST = WW'(CLK_WAIT - 1);

    typedef struct packed {
        rsm_state_e    state;
        logic [KW-1:0] kcnt;
        logic [WW-1:0] wcnt;
        logic          speed;
        logic          se0_seen;
        logic          done;
    } regs_t;

    regs_t r_q, r_d;
    logic  enter_susp;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        enter_susp = 1'b0;
        case (r_q.state)
            ST_ACTIVE: begin
                if (suspend_req) begin
                    enter_susp = 1'b1;
                    r_d.speed  = speed_hs_in;
                    r_d.state  = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (awake_i) r_d.state = ST_WAKE;
            end
            ST_WAKE: begin
                r_d.wcnt  = '0;
                r_d.state = ST_CLKWAIT;
            end
            ST_CLKWAIT: begin
                r_d.wcnt = r_q.wcnt + 1'b1;
                if (r_q.wcnt == W_LAST) begin
                    r_d.kcnt  = '0;
                    r_d.state = ST_KMEAS;
                end
            end
            ST_KMEAS: begin
                if (line_s == LINE_K) begin
                    r_d.kcnt = r_q.kcnt + 1'b1;
                    if (r_q.kcnt == K_LAST) begin
                        r_d.se0_seen = 1'b0;
                        r_d.state    = ST_EOPWAIT;
                    end
                end
            end
            ST_EOPWAIT: begin
                if (line_s == LINE_SE0) begin
                    r_d.se0_seen = 1'b1;
                end else if (line_s == LINE_J && r_q.se0_seen) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_ACTIVE;
                end
            end
            default: r_d.state = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_ACTIVE;
            r_q.kcnt     <= '0;
            r_q.wcnt     <= '0;
            r_q.speed    <= 1'b0;
            r_q.se0_seen <= 1'b0;
            r_q.done     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign suspended_o  = (r_q.state == ST_SUSP);
    assign awake_clr_o  = enter_susp;
    assign resume_done  = r_q.done;
    assign speed_hs_out = r_q.speed;

    assert_speed_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_ACTIVE) |=> $stable(r_q.speed));
    assert_wake_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAKE) |-> awake_i);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);
    assert_done_after_se0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.done) |-> $past(r_q.se0_seen) && $past(line_s) == LINE_J);
    assert_kmin_met_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_KMEAS && r_d.state == ST_EOPWAIT) |-> r_q.kcnt == K_LAST);
    assert_clkwait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CLKWAIT && r_d.state == ST_KMEAS) |-> r_q.wcnt == W_LAST);
endmodule

// File: rtl/usb_resume_seq.sv
module usb_resume_seq
    import usb_rsm_pkg::*;
#(
    parameter int K_MIN    = 1200000,
    parameter int CLK_WAIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_state,
    input  logic       suspend_req,
    input  logic       speed_hs_in,
    output logic       awake,
    output logic       phy_suspend_n,
    output logic       resume_done,
    output logic       speed_hs_out
);
    logic [1:0] line_s;
    logic       suspended, awake_clr, wake_set, flag;

    rsm_line_sync #(.WIDTH(2), .RESET_VAL(LINE_J)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_state),
        .sync_o  (line_s)
    );

    // Raw, unsynchronized K is used here because no clock may be running.
    assign wake_set = suspended && (line_state == LINE_K);

    rsm_wake_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_async (wake_set),
        .clr_sync  (awake_clr),
        .flag_o    (flag)
    );

    rsm_ctrl #(.K_MIN(K_MIN), .CLK_WAIT(CLK_WAIT)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_s       (line_s),
        .awake_i      (flag),
        .suspend_req  (suspend_req),
        .speed_hs_in  (speed_hs_in),
        .suspended_o  (suspended),
        .awake_clr_o  (awake_clr),
        .resume_done  (resume_done),
        .speed_hs_out (speed_hs_out)
    );

    assign awake         = flag;
    assign phy_suspend_n = flag;

    assert_clear_only_on_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(awake_clr));
endmodule

// File: tb/usb_resume_seq_tb.sv
module usb_resume_seq_tb;
    localparam int K_MIN    = 40;
    localparam int CLK_WAIT = 4;

    logic       clk = 1'b0;
    logic       clk_en = 1'b1;
    logic       rst_n = 1'b0;
    logic [1:0] line_state = 2'b01;
    logic       suspend_req = 1'b0;
    logic       speed_hs_in = 1'b0;
    logic       awake, phy_suspend_n, resume_done, speed_hs_out;

    int n_run = 0;
    int n_fail = 0;

    usb_resume_seq #(.K_MIN(K_MIN), .CLK_WAIT(CLK_WAIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_state(line_state),
        .suspend_req(suspend_req), .speed_hs_in(speed_hs_in),
        .awake(awake), .phy_suspend_n(phy_suspend_n),
        .resume_done(resume_done), .speed_hs_out(speed_hs_out)
    );

    initial forever begin
        #5;
        if (clk_en) clk = ~clk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected speed after a round: the value captured at entry.
    function automatic logic exp_speed(input logic captured);
        return captured;
    endfunction

    // Total K cycles the host drives: extra margin covers sync, wake and clock wait.
    function automatic int k_total(input int extra);
        return K_MIN + CLK_WAIT + 4 + extra;
    endfunction

    task automatic enter_suspend(input logic spd);
        @(negedge clk);
        line_state  = 2'b01;
        speed_hs_in = spd;
        suspend_req = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0;
        check("R2 awake low", awake, 0);
        check("R2 phy_suspend_n low", phy_suspend_n, 0);
        check("R2 speed capture", speed_hs_out, spd);
        clk_en = 1'b0;
        #1;
    endtask

    // Stopped-clock wake by K, then clock restart.
    task automatic wake_no_clock(input logic spd);
        speed_hs_in = ~spd;
        line_state = 2'b00; #20;
        line_state = 2'b11; #20;
        line_state = 2'b01; #20;
        check("R3 no wake from J/SE0/11", awake, 0);
        check("R4 phy held in suspend", phy_suspend_n, 0);
        line_state = 2'b10;
        #2;
        check("R3 async wake on K", awake, 1);
        check("R4 phy released with flag", phy_suspend_n, 1);
        #13;
        clk_en = 1'b1;
    endtask

    // Drive a code for n cycles; return whether resume_done appeared.
    task automatic drive(input logic [1:0] code, input int n, output int dones);
        dones = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_state = code;
            if (resume_done) dones++;
        end
    endtask

    task automatic expect_done(input string req, input logic spd);
        int seen = 0;
        int width = 0;
        line_state = 2'b01;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (resume_done) begin seen = 1; width++; end
        end
        check({req, " done pulse seen"}, seen, 1);
        check({req, " done one cycle"}, width, 1);
        check({req, " awake after resume"}, awake, 1);
        check("R8 speed restored", speed_hs_out, exp_speed(spd));
    endtask

    initial begin
        int d;
        int spd;
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int d;
        logic spd;
        void'($urandom(32'd2024));
        #23 rst_n = 1'b1;
        @(negedge clk);
        check("R1 awake", awake, 1);
        check("R1 phy_suspend_n", phy_suspend_n, 1);
        check("R1 resume_done", resume_done, 0);
        check("R1 speed", speed_hs_out, 0);

        // Directed: short K must not complete (R5, R6).
        enter_suspend(1'b1);
        wake_no_clock(1'b1);
        drive(2'b10, K_MIN, d);
        check("R6 no done during K", d, 0);
        drive(2'b00, 4, d);
        drive(2'b01, 8, d);
        check("R5 R6 short K no done", d, 0);
        check("R8 speed during resume", speed_hs_out, 1);
        drive(2'b10, k_total(0), d);
        check("R6 no done in long K", d, 0);
        drive(2'b00, 3, d);
        expect_done("R7", 1'b1);

        // Directed: 11 is not SE0 (R9), stray suspend request (R10).
        enter_suspend(1'b0);
        wake_no_clock(1'b0);
        drive(2'b10, 3, d);
        suspend_req = 1'b1; speed_hs_in = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0;
        check("R10 awake kept", awake, 1);
        check("R10 speed not recaptured", speed_hs_out, 0);
        drive(2'b10, k_total(0), d);
        drive(2'b11, 5, d);
        drive(2'b01, 8, d);
        check("R9 11 then J no done", d, 0);
        drive(2'b00, 2, d);
        expect_done("R9", 1'b0);

        // Random rounds.
        for (int it = 0; it < 6; it++) begin
            spd = 1'($urandom_range(0, 1));
            enter_suspend(spd);
            wake_no_clock(spd);
            drive(2'b10, k_total(int'($urandom_range(0, 30))), d);
            check("R6 random no early done", d, 0);
            speed_hs_in = ~speed_hs_in;
            drive(2'b00, int'($urandom_range(1, 5)), d);
            expect_done("R7 random", spd);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule